// File: doc/BRIEF.md
# Pseudorandom Port-to-Router Remapper

This block sits between the outgoing request ports of a small group of tiles and the same number of injection ports on parallel mesh routers. In every cycle it connects each tile port to exactly one router and each router to exactly one tile port. The assignment changes from cycle to cycle, so traffic that would otherwise pile onto one mesh is spread across all of them. Packet words pass through unchanged. Only their destination router changes.

The assignment comes from a Galois shift register that steps once per clock, whether or not there is traffic. A seed can be loaded into it synchronously. Each instance also carries a fixed rotation offset, taken from its instance number times a stride, so that neighbouring instances do not choose the same pattern. A parameter selects how the register key is combined with the port index: XOR or modular add. Either way the result is a permutation. The ready signals go back through the same permutation that steers valid and data in that cycle.

Top module: `port_remapper`

## Requirements
- R1: In every cycle each router output is driven by exactly one tile port, so the number of asserted router valids equals the number of asserted port valids.
- R2: With key = the low log2(N) bits of the state and off = (INST_ID*STRIDE) mod N, port p goes to router ((p XOR key) + off) mod N when MIX_MODE is MIX_XOR, and to router (p + key + off) mod N when MIX_MODE is MIX_ADD.
- R3: When no seed is being loaded, the state steps on every clock edge, whatever the traffic: next = (state >> 1) XOR (state[0] ? TAPS : 0), with TAPS = 16'hB400 by default. The state is never zero.
- R4: While rst_ni is low the state equals RESET_SEED, and the first cycle after release uses that key.
- R5: seed_load_i sampled high loads seed_i into the state at that edge and takes priority over stepping. A zero seed loads the value 1.
- R6: The data on a router output is bit-identical to the data of the tile port mapped onto it.
- R7: port_ready_o[p] equals rtr_ready_i of the router that port p maps to in the same cycle.
- R8: Router valid and data do not depend on rtr_ready_i. A router that is not ready still shows its source port's valid and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load seed_i into the permutation state |
| seed_i | input | LFSR_W | Seed value |
| port_valid_i | input | NUM_PORTS | Tile port request valid |
| port_data_i | input | NUM_PORTS x DATA_W | Tile port request words |
| port_ready_o | output | NUM_PORTS | Ready returned to each tile port |
| rtr_valid_o | output | NUM_PORTS | Valid to each router injection port |
| rtr_data_o | output | NUM_PORTS x DATA_W | Words to each router injection port |
| rtr_ready_i | input | NUM_PORTS | Ready from each router injection port |

## Verification
The datapath is combinational, so valid, data and ready are due in the same cycle as the stimulus, using the key of the current state. The state itself changes at the next rising edge, and a seed load becomes visible at the first sampling after that edge. The bench drives inputs on the falling edge and samples 1 ns later. It keeps a model of the state and advances it once per loop iteration, at the point that matches the following rising edge, so every comparison uses the key that is live in that cycle. Two instances are checked side by side: eight ports with XOR mixing and four ports with additive mixing.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
  typedef enum logic {
    MIX_XOR = 1'b0,
    MIX_ADD = 1'b1
  } mix_e;
endpackage

// File: rtl/rmp_state.sv
module rmp_state #(
  parameter int unsigned           LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]     TAPS       = 16'hB400,
  parameter logic [LFSR_W-1:0]     RESET_SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] state_o
);
  localparam logic [LFSR_W-1:0] ONE = LFSR_W'(1);

  logic [LFSR_W-1:0] state_q, state_d, step;

  assign step = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);

  always_comb begin
    state_d = step;
    if (seed_load_i) state_d = (seed_i == '0) ? ONE : seed_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RESET_SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rmp_perm.sv
module rmp_perm
  import rmp_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned OFFSET    = 0,
  parameter mix_e        MIX_MODE  = MIX_XOR,
  localparam int unsigned LOG_N    = $clog2(NUM_PORTS)
) (
  input  logic [LOG_N-1:0]                 key_i,
  output logic [NUM_PORTS-1:0][LOG_N-1:0]  dst_idx_o,
  output logic [NUM_PORTS-1:0][LOG_N-1:0]  src_idx_o
);
  localparam logic [LOG_N-1:0] OFF = LOG_N'(OFFSET % NUM_PORTS);

  generate
    if (MIX_MODE == MIX_XOR) begin : g_xor
      always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          dst_idx_o[p] = (LOG_N'(p) ^ key_i) + OFF;
          src_idx_o[p] = (LOG_N'(p) - OFF) ^ key_i;
        end
      end
    end else begin : g_add
      always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          dst_idx_o[p] = LOG_N'(p) + key_i + OFF;
          src_idx_o[p] = LOG_N'(p) - key_i - OFF;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rmp_xbar.sv
module rmp_xbar #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned LOG_N    = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0][LOG_N-1:0]  dst_idx_i,
  input  logic [NUM_PORTS-1:0][LOG_N-1:0]  src_idx_i,
  input  logic [NUM_PORTS-1:0]             port_valid_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] port_data_i,
  output logic [NUM_PORTS-1:0]             port_ready_o,
  output logic [NUM_PORTS-1:0]             rtr_valid_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rtr_data_o,
  input  logic [NUM_PORTS-1:0]             rtr_ready_i
);
  for (genvar r = 0; r < NUM_PORTS; r++) begin : g_fwd
    assign rtr_valid_o[r] = port_valid_i[src_idx_i[r]];
    assign rtr_data_o[r]  = port_data_i[src_idx_i[r]];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bwd
    assign port_ready_o[p] = rtr_ready_i[dst_idx_i[p]];
  end
endmodule

// File: rtl/port_remapper.sv
module port_remapper
  import rmp_pkg::*;
#(
  parameter int unsigned         NUM_PORTS  = 8,
  parameter int unsigned         DATA_W     = 32,
  parameter int unsigned         LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]   TAPS       = 16'hB400,
  parameter logic [LFSR_W-1:0]   RESET_SEED = 16'hACE1,
  parameter int unsigned         INST_ID    = 0,
  parameter int unsigned         STRIDE     = 1,
  parameter mix_e                MIX_MODE   = MIX_XOR
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             seed_load_i,
  input  logic [LFSR_W-1:0]                seed_i,
  input  logic [NUM_PORTS-1:0]             port_valid_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] port_data_i,
  output logic [NUM_PORTS-1:0]             port_ready_o,
  output logic [NUM_PORTS-1:0]             rtr_valid_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rtr_data_o,
  input  logic [NUM_PORTS-1:0]             rtr_ready_i
);
  localparam int unsigned LOG_N  = $clog2(NUM_PORTS);
  localparam int unsigned OFFSET = (INST_ID * STRIDE) % NUM_PORTS;

  logic [LFSR_W-1:0]                lfsr_state;
  logic [NUM_PORTS-1:0][LOG_N-1:0]  dst_idx, src_idx;

  rmp_state #(
    .LFSR_W(LFSR_W), .TAPS(TAPS), .RESET_SEED(RESET_SEED)
  ) i_state (
    .clk_i, .rst_ni, .seed_load_i, .seed_i, .state_o(lfsr_state)
  );

  rmp_perm #(
    .NUM_PORTS(NUM_PORTS), .OFFSET(OFFSET), .MIX_MODE(MIX_MODE)
  ) i_perm (
    .key_i(lfsr_state[LOG_N-1:0]), .dst_idx_o(dst_idx), .src_idx_o(src_idx)
  );

  rmp_xbar #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)
  ) i_xbar (
    .dst_idx_i(dst_idx), .src_idx_i(src_idx),
    .port_valid_i, .port_data_i, .port_ready_o,
    .rtr_valid_o, .rtr_data_o, .rtr_ready_i
  );
endmodule

// File: rtl/rmp_checker.sv
module rmp_checker #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned LFSR_W    = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 seed_load_i,
  input logic [LFSR_W-1:0]    seed_i,
  input logic [LFSR_W-1:0]    state_i,
  input logic [NUM_PORTS-1:0] port_valid_i,
  input logic [NUM_PORTS-1:0] rtr_valid_o,
  input logic [NUM_PORTS-1:0] port_ready_o,
  input logic [NUM_PORTS-1:0] rtr_ready_i
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  p_valid_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rtr_valid_o) == $countones(port_valid_i));

  p_state_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != '0);

  p_state_moves_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && !$past(seed_load_i) |-> state_i != $past(state_i));

  p_seed_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> state_i == (($past(seed_i) == '0) ? LFSR_W'(1) : $past(seed_i)));

  p_ready_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(port_ready_o) == $countones(rtr_ready_i));
endmodule

bind port_remapper rmp_checker #(
  .NUM_PORTS(NUM_PORTS), .LFSR_W(LFSR_W)
) i_rmp_checker (
  .clk_i, .rst_ni, .seed_load_i, .seed_i, .state_i(lfsr_state),
  .port_valid_i, .rtr_valid_o, .port_ready_o, .rtr_ready_i
);

// File: tb/test_port_remapper.sv
`timescale 1ns/1ps
module test_port_remapper;
  import rmp_pkg::*;

  localparam int NA = 8, NB = 4, DW = 32;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam logic [15:0] SEED_A = 16'hACE1, SEED_B = 16'h1D0F;
  localparam int OFF_A = (3 * 3) % NA;  // INST_ID 3, STRIDE 3
  localparam int OFF_B = (1 * 2) % NB;  // INST_ID 1, STRIDE 2

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic            ld_a, ld_b;
  logic [15:0]     sd_a, sd_b;
  logic [NA-1:0]   pv_a, pr_a, rv_a, rr_a;
  logic [NA-1:0][DW-1:0] pd_a, rd_a;
  logic [NB-1:0]   pv_b, pr_b, rv_b, rr_b;
  logic [NB-1:0][DW-1:0] pd_b, rd_b;

  port_remapper #(.NUM_PORTS(NA), .DATA_W(DW), .RESET_SEED(SEED_A),
    .INST_ID(3), .STRIDE(3), .MIX_MODE(MIX_XOR)) i_port_remapper (
    .clk_i, .rst_ni, .seed_load_i(ld_a), .seed_i(sd_a),
    .port_valid_i(pv_a), .port_data_i(pd_a), .port_ready_o(pr_a),
    .rtr_valid_o(rv_a), .rtr_data_o(rd_a), .rtr_ready_i(rr_a));

  port_remapper #(.NUM_PORTS(NB), .DATA_W(DW), .RESET_SEED(SEED_B),
    .INST_ID(1), .STRIDE(2), .MIX_MODE(MIX_ADD)) i_port_remapper_b (
    .clk_i, .rst_ni, .seed_load_i(ld_b), .seed_i(sd_b),
    .port_valid_i(pv_b), .port_data_i(pd_b), .port_ready_o(pr_b),
    .rtr_valid_o(rv_b), .rtr_data_o(rd_b), .rtr_ready_i(rr_b));

  int n_chk = 0, n_fail = 0;
  logic [15:0] st_a, st_b;
  bit done = 0;

  function automatic logic [15:0] step(logic [15:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 16'h0);
  endfunction

  function automatic int dst(int p, logic [15:0] s, int n, bit add, int off);
    int key = int'(s) & (n - 1);
    if (add) return (p + key + off) % n;
    return ((p ^ key) + off) % n;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R2 R6 R8 routing, R1 count, R7 ready for instance A
  task automatic check_a(string tag);
    bit ok_v = 1, ok_d = 1, ok_r = 1;
    longint av = 0, ev = 0;
    for (int p = 0; p < NA; p++) begin
      int r = dst(p, st_a, NA, 0, OFF_A);
      if (rv_a[r] !== pv_a[p]) ok_v = 0;
      if (rd_a[r] !== pd_a[p]) begin ok_d = 0; av = rd_a[r]; ev = pd_a[p]; end
      if (pr_a[p] !== rr_a[r]) ok_r = 0;
    end
    chk(ok_v, {"R2 ", tag}, "A valid route", rv_a, pv_a);
    chk(ok_d, "R6", "A data", av, ev);
    chk(ok_r, "R7", "A ready", pr_a, rr_a);
    chk($countones(rv_a) == $countones(pv_a), "R1", "A valid count", rv_a, pv_a);
  endtask

  task automatic check_b(string tag);
    bit ok_v = 1, ok_d = 1, ok_r = 1;
    longint av = 0, ev = 0;
    for (int p = 0; p < NB; p++) begin
      int r = dst(p, st_b, NB, 1, OFF_B);
      if (rv_b[r] !== pv_b[p]) ok_v = 0;
      if (rd_b[r] !== pd_b[p]) begin ok_d = 0; av = rd_b[r]; ev = pd_b[p]; end
      if (pr_b[p] !== rr_b[r]) ok_r = 0;
    end
    chk(ok_v, {"R2 ", tag}, "B valid route", rv_b, pv_b);
    chk(ok_d, "R6", "B data", av, ev);
    chk(ok_r, "R7", "B ready", pr_b, rr_b);
  endtask

  task automatic advance();
    st_a = ld_a ? ((sd_a == 0) ? 16'h1 : sd_a) : step(st_a);
    st_b = ld_b ? ((sd_b == 0) ? 16'h1 : sd_b) : step(st_b);
  endtask

  task automatic rand_drive(bit allow_ld);
    pv_a = NA'($urandom); rr_a = NA'($urandom);
    pv_b = NB'($urandom); rr_b = NB'($urandom);
    for (int p = 0; p < NA; p++) pd_a[p] = $urandom;
    for (int p = 0; p < NB; p++) pd_b[p] = $urandom;
    ld_a = allow_ld && ($urandom_range(0, 15) == 0);
    ld_b = allow_ld && ($urandom_range(0, 15) == 0);
    sd_a = 16'($urandom); sd_b = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    ld_a = 0; ld_b = 0; sd_a = 0; sd_b = 0;
    pv_a = '1; rr_a = '1; pv_b = '1; rr_b = '1;
    for (int p = 0; p < NA; p++) pd_a[p] = DW'(32'hA000 + p);
    for (int p = 0; p < NB; p++) pd_b[p] = DW'(32'hB000 + p);
    st_a = SEED_A; st_b = SEED_B;
    repeat (3) @(negedge clk_i);
    #1;
    // R4: state held at reset seed during reset
    check_a("R4 in reset"); check_b("R4 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    check_a("R4 first key"); check_b("R4 first key");
    advance();

    // R8: routers not ready, valid and data still steered
    @(negedge clk_i); rr_a = '0; rr_b = '0; #1;
    check_a("R8 not ready"); check_b("R8 not ready");
    advance();

    // R5: zero seed loads 1, then R3 stepping from 1
    @(negedge clk_i); ld_a = 1; sd_a = 16'h0; ld_b = 1; sd_b = 16'h0; #1;
    check_a("R5 pre"); check_b("R5 pre");
    advance();
    @(negedge clk_i); ld_a = 0; ld_b = 0; #1;
    chk(st_a == 16'h1, "R5", "model zero seed", st_a, 1);
    check_a("R5 zero seed"); check_b("R5 zero seed");
    advance();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i); pv_a = NA'(i * 37); pv_b = NB'(i); rr_a = ~pv_a; #1;
      check_a("R3 step"); check_b("R3 step");
      advance();
    end

    // R5: nonzero seed, held load keeps key constant
    @(negedge clk_i); ld_a = 1; sd_a = 16'h5A5B; ld_b = 1; sd_b = 16'h0006; #1;
    advance();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); #1;
      check_a("R5 held load"); check_b("R5 held load");
      advance();
    end
    @(negedge clk_i); ld_a = 0; ld_b = 0; #1;
    advance();

    // random traffic, R3 advance regardless of valids, occasional loads
    for (int c = 0; c < 400; c++) begin
      @(negedge clk_i);
      rand_drive(1);
      #1;
      check_a("R3 random"); check_b("R3 random");
      advance();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule